// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the register file that software uses to steer a 64-channel DMA controller. It sits on a plain 32-bit register bus with big-endian byte lanes. It holds one bit per channel for several things: whether requests are allowed, whether errors may interrupt, pending interrupt requests, error flags, and an interrupt route select. It also holds one priority byte per channel and three arbitration and clock mode bits. Software rarely rewrites the wide per-channel vectors directly. It normally writes a channel index into one of eight byte-wide command slots, and each slot sets or clears that channel's bit in one vector. Two of the slots instead issue start or clear-done pulses toward the transfer engines.

The transfer engines send back interrupt events as per-channel pulses, and send error reports as a pulse that carries a channel number and a ten-bit cause code. The first error report is frozen in an error status word until software clears that channel's error. A single interrupt line summarises pending requests and enabled errors. Reads have no side effects, and the read data follows the address combinationally.

Top module: `dma_chreg_bank`

## Requirements
- R1: After reset, every per-channel vector, the error status word and the control word read zero, and `irq_o` is low.
- R2: Bus byte address 0x18+k is carried on data bits [31-8k -: 8] and qualified by enable bit 3-k, so the lanes are big-endian. A channel number in bits 5:0 written to the set-request-enable slot (0x18) or the set-error-interrupt-enable slot (0x1A) sets only that channel's bit. The same value written to the clear slots 0x19 or 0x1B clears only that bit.
- R3: A command byte with bit 6 set applies its operation to all 64 channels.
- R4: A command byte with bit 7 set changes nothing and produces no pulse.
- R5: A channel number written to the start slot (0x1E) makes `start_o` pulse for exactly that channel during the one cycle after the write edge.
- R6: A channel number written to the clear-done slot (0x1F) makes `done_clr_o` pulse for that channel during the one cycle after the write edge.
- R7: An `evt_int_i` pulse sets interrupt-request bits. Writing ones to the interrupt words (0x20/0x24) or to the error words (0x28/0x2C) clears those bits. If a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R8: The clear-interrupt slot (0x1C) clears one channel's interrupt-request bit, and the clear-error slot (0x1D) clears one channel's error bit.
- R9: An error report sets the bit for its channel. The first report while the status word is not valid loads the status as follows: bit 31 = 1, bit 15 = code[9], bit 14 = code[8], bits 13:8 = channel, bits 7:0 = code[7:0]. Later reports leave the status unchanged. A clear-error command that covers the captured channel clears the whole status word.
- R10: `irq_o` is high when any interrupt-request bit is set, or when any error bit is set for a channel whose error-interrupt-enable bit is set.
- R11: The control word at 0x00 keeps only bit 31 (clock gating enable), bit 3 (round-robin group) and bit 2 (round-robin channel). These drive `clk_gate_o`, `rr_group_o` and `rr_chan_o`, and all other bits read zero.
- R12: Each vector appears as a high word for channels 63..32 at the lower address (0x08, 0x10, 0x20, 0x28, 0x30, 0x38) and a low word for channels 31..0 four bytes above it. Bit i of the low word is channel i, and bit i of the high word is channel 32+i.
- R13: The priority byte of channel n sits at byte address 0x100+n and drives `prio_o[8n +: 8]`. The route select words at 0x38/0x3C can be read and written and drive `route_o`.
- R14: The command words 0x18 and 0x1C read zero. The hardware-request status words (0x30/0x34) read the live `hw_req_i` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 12 | Byte address (word aligned) |
| bus_be_i | input | 4 | Byte enables, bit 3 = lowest byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| evt_int_i | input | 64 | Per-channel interrupt event pulses |
| err_evt_i | input | 1 | Error report pulse |
| err_chan_i | input | 6 | Channel of the error report |
| err_code_i | input | 10 | Cause code of the error report |
| hw_req_i | input | 64 | Live hardware request lines |
| req_en_o | output | 64 | Request enable vector |
| route_o | output | 64 | Interrupt route select vector |
| prio_o | output | 512 | Priority bytes, channel n at [8n +: 8] |
| clk_gate_o | output | 1 | Clock gating enable |
| rr_group_o | output | 1 | Round-robin group arbitration |
| rr_chan_o | output | 1 | Round-robin channel arbitration |
| start_o | output | 64 | Start pulses |
| done_clr_o | output | 64 | Clear-done pulses |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the frozen error status. To reach it, a first report has to be captured, a second report on another channel has to arrive and leave the status untouched, and only a clear aimed at the captured channel may release the status. The bench reaches it by sending two reports with distinct channels and codes. It then clears the non-captured channel first, clears the captured channel next, and finally sends a third report to show that capture re-arms. A second hard case is a collision between a write-one-to-clear and a new event in the same cycle. The bench drives both inputs in one cycle.

// File: rtl/dma_chreg_pkg.sv
package dma_chreg_pkg;
  localparam int NCH = 64;
  localparam int CHW = $clog2(NCH);
  localparam int DW  = 32;
  localparam int AW  = 12;
  localparam int PW  = 8;
  localparam int WAW = AW - 2;

  localparam logic [WAW-1:0] W_CTRL  = 10'd0;
  localparam logic [WAW-1:0] W_ESTAT = 10'd1;
  localparam logic [WAW-1:0] W_REQH  = 10'd2;
  localparam logic [WAW-1:0] W_REQL  = 10'd3;
  localparam logic [WAW-1:0] W_EEIH  = 10'd4;
  localparam logic [WAW-1:0] W_EEIL  = 10'd5;
  localparam logic [WAW-1:0] W_CMD0  = 10'd6;
  localparam logic [WAW-1:0] W_CMD1  = 10'd7;
  localparam logic [WAW-1:0] W_INTH  = 10'd8;
  localparam logic [WAW-1:0] W_INTL  = 10'd9;
  localparam logic [WAW-1:0] W_ERRH  = 10'd10;
  localparam logic [WAW-1:0] W_ERRL  = 10'd11;
  localparam logic [WAW-1:0] W_HRSH  = 10'd12;
  localparam logic [WAW-1:0] W_HRSL  = 10'd13;
  localparam logic [WAW-1:0] W_RTEH  = 10'd14;
  localparam logic [WAW-1:0] W_RTEL  = 10'd15;
  localparam logic [5:0]     W_PRIO_HI = 6'h04;

  // command slot order follows byte address 0x18..0x1F
  typedef enum logic [2:0] {
    C_SET_REQ = 3'd0, C_CLR_REQ = 3'd1, C_SET_EEI = 3'd2, C_CLR_EEI = 3'd3,
    C_CLR_INT = 3'd4, C_CLR_ERR = 3'd5, C_START   = 3'd6, C_CLR_DONE = 3'd7
  } cmd_slot_e;

  function automatic logic [DW-1:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/dma_cmd_dec.sv
module dma_cmd_dec #(
  parameter int N   = 64,
  parameter int CHW = 6
) (
  input  logic         en_i,
  input  logic [7:0]   cmd_i,
  output logic [N-1:0] mask_o
);
  always_comb begin
    mask_o = '0;
    if (en_i && !cmd_i[7]) begin
      if (cmd_i[6]) mask_o = '1;
      else          mask_o[cmd_i[CHW-1:0]] = 1'b1;
    end
  end
endmodule

// File: rtl/dma_bitvec.sv
module dma_bitvec #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = |(set_i | clr_i);
    q_d  = (q_o & ~clr_i) | set_i;  // set wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture #(
  parameter int N   = 64,
  parameter int CHW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_i,
  input  logic [CHW-1:0] chan_i,
  input  logic [9:0]     code_i,
  input  logic [N-1:0]   clr_mask_i,
  output logic [31:0]    stat_o,
  output logic [N-1:0]   set_o
);
  logic [31:0] stat_d;
  logic        hit;
  logic        stat_en;

  always_comb begin
    hit    = stat_o[31] && clr_mask_i[stat_o[8 +: CHW]];
    stat_d = hit ? 32'h0 : stat_o;
    if (evt_i && !stat_d[31])
      stat_d = {1'b1, 15'h0, code_i[9], code_i[8], 6'(chan_i), code_i[7:0]};
    stat_en = hit | evt_i;
    set_o   = '0;
    if (evt_i) set_o[chan_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_o <= '0;
    else if (stat_en) stat_o <= stat_d;
  end
endmodule

// File: rtl/dma_chreg_bank.sv
module dma_chreg_bank
  import dma_chreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [3:0]        bus_be_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic [NCH-1:0]    evt_int_i,
  input  logic              err_evt_i,
  input  logic [CHW-1:0]    err_chan_i,
  input  logic [9:0]        err_code_i,
  input  logic [NCH-1:0]    hw_req_i,
  output logic [NCH-1:0]    req_en_o,
  output logic [NCH-1:0]    route_o,
  output logic [NCH*PW-1:0] prio_o,
  output logic              clk_gate_o,
  output logic              rr_group_o,
  output logic              rr_chan_o,
  output logic [NCH-1:0]    start_o,
  output logic [NCH-1:0]    done_clr_o,
  output logic              irq_o
);
  logic [WAW-1:0] waddr;
  logic [DW-1:0]  bmask;
  logic [NCH-1:0] cmd_m [8];
  logic [NCH-1:0] eei_q, int_q, err_q, err_set;
  logic [31:0]    err_stat_q;
  logic [2:0]     ctrl_q, ctrl_d;
  logic           ctrl_en;
  logic [NCH-1:0] start_q, dclr_q;
  logic [PW-1:0]  prio_q [NCH];
  logic [NCH-1:0] prio_we;

  assign waddr = bus_addr_i[AW-1:2];
  assign bmask = lane_mask(bus_be_i);

  function automatic logic [NCH-1:0] word_bits(input logic hit_h, input logic hit_l,
                                               input logic [DW-1:0] v);
    return {hit_h ? v : 32'h0, hit_l ? v : 32'h0};
  endfunction

  // eight byte-wide command slots, big-endian lanes
  for (genvar i = 0; i < 8; i++) begin : g_cmd
    localparam logic [WAW-1:0] CW = (i < 4) ? W_CMD0 : W_CMD1;
    localparam int L = i % 4;
    dma_cmd_dec #(.N(NCH), .CHW(CHW)) u_dec (
      .en_i  (bus_wr_i && waddr == CW && bus_be_i[3-L]),
      .cmd_i (bus_wdata_i[31-8*L -: 8]),
      .mask_o(cmd_m[i])
    );
  end

  logic wr_reqh, wr_reql, wr_eeih, wr_eeil, wr_inth, wr_intl, wr_errh, wr_errl, wr_rteh, wr_rtel;
  always_comb begin
    wr_reqh = bus_wr_i && waddr == W_REQH;
    wr_reql = bus_wr_i && waddr == W_REQL;
    wr_eeih = bus_wr_i && waddr == W_EEIH;
    wr_eeil = bus_wr_i && waddr == W_EEIL;
    wr_inth = bus_wr_i && waddr == W_INTH;
    wr_intl = bus_wr_i && waddr == W_INTL;
    wr_errh = bus_wr_i && waddr == W_ERRH;
    wr_errl = bus_wr_i && waddr == W_ERRL;
    wr_rteh = bus_wr_i && waddr == W_RTEH;
    wr_rtel = bus_wr_i && waddr == W_RTEL;
  end

  dma_bitvec #(.N(NCH)) u_req (.clk(clk), .rst_n(rst_n),
    .set_i(word_bits(wr_reqh, wr_reql, bmask & bus_wdata_i) | cmd_m[C_SET_REQ]),
    .clr_i(word_bits(wr_reqh, wr_reql, bmask) | cmd_m[C_CLR_REQ]),
    .q_o(req_en_o));

  dma_bitvec #(.N(NCH)) u_eei (.clk(clk), .rst_n(rst_n),
    .set_i(word_bits(wr_eeih, wr_eeil, bmask & bus_wdata_i) | cmd_m[C_SET_EEI]),
    .clr_i(word_bits(wr_eeih, wr_eeil, bmask) | cmd_m[C_CLR_EEI]),
    .q_o(eei_q));

  dma_bitvec #(.N(NCH)) u_int (.clk(clk), .rst_n(rst_n),
    .set_i(evt_int_i),
    .clr_i(word_bits(wr_inth, wr_intl, bmask & bus_wdata_i) | cmd_m[C_CLR_INT]),
    .q_o(int_q));

  dma_bitvec #(.N(NCH)) u_err (.clk(clk), .rst_n(rst_n),
    .set_i(err_set),
    .clr_i(word_bits(wr_errh, wr_errl, bmask & bus_wdata_i) | cmd_m[C_CLR_ERR]),
    .q_o(err_q));

  dma_bitvec #(.N(NCH)) u_rte (.clk(clk), .rst_n(rst_n),
    .set_i(word_bits(wr_rteh, wr_rtel, bmask & bus_wdata_i)),
    .clr_i(word_bits(wr_rteh, wr_rtel, bmask)),
    .q_o(route_o));

  dma_err_capture #(.N(NCH), .CHW(CHW)) u_ecap (
    .clk(clk), .rst_n(rst_n), .evt_i(err_evt_i), .chan_i(err_chan_i),
    .code_i(err_code_i), .clr_mask_i(cmd_m[C_CLR_ERR]),
    .stat_o(err_stat_q), .set_o(err_set));

  // control word: {clock gate, rr group, rr channel}
  always_comb begin
    ctrl_en = bus_wr_i && waddr == W_CTRL;
    ctrl_d  = ctrl_q;
    if (bus_be_i[3]) ctrl_d[2]   = bus_wdata_i[31];
    if (bus_be_i[0]) ctrl_d[1:0] = bus_wdata_i[3:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= '0;
      dclr_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      start_q <= cmd_m[C_START];
      dclr_q  <= cmd_m[C_CLR_DONE];
    end
  end

  // priority bytes, channel n at byte address 0x100 + n
  for (genvar n = 0; n < NCH; n++) begin : g_prio
    localparam int L = n % 4;
    assign prio_we[n] = bus_wr_i && waddr[WAW-1:4] == W_PRIO_HI &&
                        waddr[3:0] == 4'(n / 4) && bus_be_i[3-L];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prio_q[n] <= '0;
      else if (prio_we[n]) prio_q[n] <= bus_wdata_i[31-8*L -: 8];
    end
    assign prio_o[n*PW +: PW] = prio_q[n];
  end

  logic [5:0] pb;
  always_comb begin
    pb = {waddr[3:0], 2'b00};
    bus_rdata_o = '0;
    case (waddr)
      W_CTRL:  bus_rdata_o = {ctrl_q[2], 27'h0, ctrl_q[1:0], 2'b00};
      W_ESTAT: bus_rdata_o = err_stat_q;
      W_REQH:  bus_rdata_o = req_en_o[63:32];
      W_REQL:  bus_rdata_o = req_en_o[31:0];
      W_EEIH:  bus_rdata_o = eei_q[63:32];
      W_EEIL:  bus_rdata_o = eei_q[31:0];
      W_INTH:  bus_rdata_o = int_q[63:32];
      W_INTL:  bus_rdata_o = int_q[31:0];
      W_ERRH:  bus_rdata_o = err_q[63:32];
      W_ERRL:  bus_rdata_o = err_q[31:0];
      W_HRSH:  bus_rdata_o = hw_req_i[63:32];
      W_HRSL:  bus_rdata_o = hw_req_i[31:0];
      W_RTEH:  bus_rdata_o = route_o[63:32];
      W_RTEL:  bus_rdata_o = route_o[31:0];
      default: if (waddr[WAW-1:4] == W_PRIO_HI)
                 bus_rdata_o = {prio_q[pb], prio_q[pb + 6'd1], prio_q[pb + 6'd2], prio_q[pb + 6'd3]};
    endcase
  end

  assign clk_gate_o = ctrl_q[2];
  assign rr_group_o = ctrl_q[1];
  assign rr_chan_o  = ctrl_q[0];
  assign start_o    = start_q;
  assign done_clr_o = dclr_q;
  assign irq_o      = (|int_q) | (|(err_q & eei_q));
endmodule

// File: rtl/dma_chreg_chk.sv
module dma_chreg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_i,
  input logic [11:0] bus_addr_i,
  input logic [3:0]  bus_be_i,
  input logic [31:0] bus_wdata_i,
  input logic [63:0] evt_int_i,
  input logic        err_evt_i,
  input logic [5:0]  err_chan_i,
  input logic [63:0] start_o,
  input logic        irq_o,
  input logic [31:0] err_stat,
  input logic [63:0] err_vec
);
  logic start_wr, clr_err_wr;
  assign start_wr   = bus_wr_i && bus_addr_i[11:2] == 10'd7 && bus_be_i[1];
  assign clr_err_wr = bus_wr_i && bus_addr_i[11:2] == 10'd7 && bus_be_i[2] && !bus_wdata_i[23];

  a_r5_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != 64'h0) |-> $past(start_wr && !bus_wdata_i[15]));

  a_r5_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && bus_wdata_i[15:14] == 2'b00) |=> ($countones(start_o) == 1));

  a_r4_noop_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && bus_wdata_i[15]) |=> (start_o == 64'h0));

  a_r10_irq_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_int_i != 64'h0) |=> irq_o);

  a_r9_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stat[31] && !clr_err_wr) |=> $stable(err_stat));

  a_r7_err_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i |=> err_vec[$past(err_chan_i)]);
endmodule

bind dma_chreg_bank dma_chreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_be_i(bus_be_i), .bus_wdata_i(bus_wdata_i), .evt_int_i(evt_int_i),
  .err_evt_i(err_evt_i), .err_chan_i(err_chan_i), .start_o(start_o),
  .irq_o(irq_o), .err_stat(err_stat_q), .err_vec(err_q));

// File: tb/dma_chreg_bank_bench.sv
module dma_chreg_bank_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_wr;
  logic [11:0]  bus_addr;
  logic [3:0]   bus_be;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [63:0]  evt_int;
  logic         err_evt;
  logic [5:0]   err_chan;
  logic [9:0]   err_code;
  logic [63:0]  hw_req;
  logic [63:0]  req_en, route, start, done_clr;
  logic [511:0] prio;
  logic         clk_gate, rr_group, rr_chan, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_chreg_bank u_dma_chreg_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_be_i(bus_be), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .evt_int_i(evt_int), .err_evt_i(err_evt), .err_chan_i(err_chan),
    .err_code_i(err_code), .hw_req_i(hw_req), .req_en_o(req_en),
    .route_o(route), .prio_o(prio), .clk_gate_o(clk_gate),
    .rr_group_o(rr_group), .rr_chan_o(rr_chan), .start_o(start),
    .done_clr_o(done_clr), .irq_o(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, {32'h0, d}, {32'h0, exp});
  endtask

  task automatic err_report(input logic [5:0] c, input logic [9:0] code);
    @(negedge clk);
    err_evt = 1'b1; err_chan = c; err_code = code;
    @(negedge clk);
    err_evt = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 12'h000, 32'h0);
    rd_chk("R1 estat", 12'h004, 32'h0);
    rd_chk("R1 reqh", 12'h008, 32'h0);
    rd_chk("R1 intl", 12'h024, 32'h0);
    rd_chk("R1 errl", 12'h02C, 32'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_setclr;
    wr(12'h018, 4'b1000, 32'h0500_0000);           // set req ch5
    rd_chk("R2 set ch5 low", 12'h00C, 32'h0000_0020);
    wr(12'h018, 4'b1000, 32'h2800_0000);           // set req ch40
    rd_chk("R12 ch40 high word", 12'h008, 32'h0000_0100);
    wr(12'h018, 4'b0100, 32'h0005_0000);           // clear req ch5
    rd_chk("R2 clr ch5", 12'h00C, 32'h0);
    chk("R2 req_en_o", req_en, 64'h0000_0100_0000_0000);
    wr(12'h018, 4'b0010, 32'h0000_0300);           // set eei ch3
    rd_chk("R2 set eei ch3", 12'h014, 32'h0000_0008);
    wr(12'h018, 4'b0001, 32'h0000_0003);           // clear eei ch3
    rd_chk("R2 clr eei ch3", 12'h014, 32'h0);
  endtask

  task automatic t_all;
    wr(12'h018, 4'b0010, 32'h0000_4000);
    rd_chk("R3 eei all high", 12'h010, 32'hFFFF_FFFF);
    rd_chk("R3 eei all low", 12'h014, 32'hFFFF_FFFF);
    wr(12'h018, 4'b0001, 32'h0000_0040);
    rd_chk("R3 eei none", 12'h010, 32'h0);
    wr(12'h018, 4'b0100, 32'h0040_0000);           // clear all req
    chk("R3 req cleared", req_en, 64'h0);
  endtask

  task automatic t_noop;
    wr(12'h018, 4'b1000, 32'h8500_0000);
    chk("R4 no set", req_en, 64'h0);
    wr(12'h01C, 4'b0010, 32'h0000_C300);
    chk("R4 no start", start, 64'h0);
  endtask

  task automatic t_start;
    wr(12'h01C, 4'b0010, 32'h0000_2500);           // start ch37
    chk("R5 start pulse", start, 64'h1 << 37);
    @(negedge clk);
    chk("R5 pulse ends", start, 64'h0);
    wr(12'h01C, 4'b0001, 32'h0000_0002);           // clear done ch2
    chk("R6 done pulse", done_clr, 64'h4);
    @(negedge clk);
    chk("R6 pulse ends", done_clr, 64'h0);
  endtask

  task automatic t_int;
    @(negedge clk); evt_int = (64'h1 << 33) | 64'h8;
    @(negedge clk); evt_int = '0;
    rd_chk("R7 int low", 12'h024, 32'h8);
    rd_chk("R7 int high", 12'h020, 32'h2);
    chk("R10 irq from int", {63'h0, irq}, 64'h1);
    wr(12'h024, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R7 w1c low", 12'h024, 32'h0);
    rd_chk("R7 high kept", 12'h020, 32'h2);
    wr(12'h01C, 4'b1000, 32'h2100_0000);           // clear int ch33
    rd_chk("R8 clr int ch33", 12'h020, 32'h0);
    chk("R10 irq low", {63'h0, irq}, 64'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h024; bus_be = 4'hF; bus_wdata = 32'hFFFF_FFFF;
    evt_int = 64'h10;
    @(negedge clk);
    bus_wr = 1'b0; evt_int = '0;
    rd_chk("R7 set wins", 12'h024, 32'h10);
    wr(12'h024, 4'hF, 32'h10);
  endtask

  task automatic t_err;
    err_report(6'd10, 10'h205);
    rd_chk("R9 first capture", 12'h004, 32'h8000_8A05);
    rd_chk("R9 err bit 10", 12'h02C, 32'h0000_0400);
    chk("R10 err masked", {63'h0, irq}, 64'h0);
    err_report(6'd50, 10'h002);
    rd_chk("R9 status held", 12'h004, 32'h8000_8A05);
    rd_chk("R9 err bit 50", 12'h028, 32'h0004_0000);
    wr(12'h018, 4'b0010, 32'h0000_3200);           // eei ch50
    chk("R10 err enabled", {63'h0, irq}, 64'h1);
    wr(12'h01C, 4'b0100, 32'h0032_0000);           // clear err ch50
    rd_chk("R9 other clear keeps", 12'h004, 32'h8000_8A05);
    chk("R8 irq after clr err", {63'h0, irq}, 64'h0);
    wr(12'h01C, 4'b0100, 32'h000A_0000);           // clear err ch10
    rd_chk("R9 status cleared", 12'h004, 32'h0);
    rd_chk("R8 err low cleared", 12'h02C, 32'h0);
    err_report(6'd7, 10'h100);
    rd_chk("R9 recapture", 12'h004, 32'h8000_4700);
    wr(12'h028, 4'hF, 32'hFFFF_FFFF);
    wr(12'h02C, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R7 err w1c", 12'h02C, 32'h0);
    wr(12'h01C, 4'b0100, 32'h0040_0000);
    rd_chk("R9 clear all", 12'h004, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(12'h000, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R11 ctrl bits", 12'h000, 32'h8000_000C);
    chk("R11 outputs", {61'h0, clk_gate, rr_group, rr_chan}, 64'h7);
    wr(12'h000, 4'b0001, 32'h0000_0004);
    chk("R11 partial", {61'h0, clk_gate, rr_group, rr_chan}, 64'h5);
  endtask

  task automatic t_prio;
    wr(12'h104, 4'hF, 32'h1122_3344);
    chk("R13 prio ch4", {56'h0, prio[4*8 +: 8]}, 64'h11);
    chk("R13 prio ch7", {56'h0, prio[7*8 +: 8]}, 64'h44);
    wr(12'h13C, 4'b0100, 32'h00AB_0000);
    chk("R13 prio ch61", {56'h0, prio[61*8 +: 8]}, 64'hAB);
    rd_chk("R13 prio read", 12'h104, 32'h1122_3344);
    wr(12'h03C, 4'hF, 32'h0000_0005);
    chk("R13 route", route, 64'h5);
    rd_chk("R13 route read", 12'h03C, 32'h5);
  endtask

  task automatic t_misc;
    rd_chk("R14 cmd0 reads 0", 12'h018, 32'h0);
    rd_chk("R14 cmd1 reads 0", 12'h01C, 32'h0);
    hw_req = 64'hDEAD_0000_0000_BEEF;
    rd_chk("R14 hrs high", 12'h030, 32'hDEAD_0000);
    rd_chk("R14 hrs low", 12'h034, 32'h0000_BEEF);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    evt_int = '0; err_evt = 1'b0; err_chan = '0; err_code = '0; hw_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setclr();
    t_all();
    t_noop();
    t_start();
    t_int();
    t_err();
    t_ctrl();
    t_prio();
    t_misc();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule